// File: doc/BRIEF.md
# CAN Mailbox Interrupt Aggregator

This block keeps the interrupt bookkeeping for a 32-mailbox CAN controller. The message engine pulses one set line per mailbox. Each pulse latches a pending flag that stays up until software clears it. A per-mailbox mask decides which pending flags reach a single combined mailbox interrupt line. Software reads the flag vector to find which mailbox raised the line.

When the receive FIFO is switched on, the lowest flag bits change meaning. Bit 5 then reports that frames are waiting in the FIFO. Bits 4:0 can no longer be set, read as zero and never raise the combined line.

Five status sources sit beside the mailboxes: bus-off, error, transmit warning, receive warning and wakeup. Each one has a sticky status bit and its own interrupt output, gated by an enable. The four fault enables live in a control word. The wakeup enable lives in a separate configuration word.

Top module: `can_mb_irq_agg`

## Requirements
- R1: After reset, flag, mask, status and every enable are zero, and every interrupt output is low.
- R2: A high `mb_set[i]` in a cycle makes `flag_q[i]` read 1 after the next rising edge. The bit then holds with no further pulses until it is cleared.
- R3: A write with `wr_sel` = 0 clears each flag bit whose `wr_data` bit is 1. Flag bits whose `wr_data` bit is 0 keep their value.
- R4: If `mb_set[i]` and a clearing write to bit i arrive in the same cycle, the flag ends up set.
- R5: `irq_mb` is high exactly when some visible flag bit and the mask bit at the same position are both 1.
- R6: A write with `wr_sel` = 1 loads `mask_q` from `wr_data` at the next edge and leaves the flag bits unchanged.
- R7: While `fifo_en` is 1, flag bits 4:0 read 0, cannot be set, and do not drive `irq_mb`. Their stored state is discarded, so they stay 0 after `fifo_en` drops. Bit 5 behaves as an ordinary flag in both modes.
- R8: Status bits are ordered bit0 bus-off, bit1 error, bit2 transmit warning, bit3 receive warning, bit4 wakeup. `st_set[k]` sets status bit k. A write with `wr_sel` = 2 clears the status bits whose data bit is 1. A set wins over a clear in the same cycle.
- R9: `irq_st[k]` is status bit k ANDed with its enable. A write with `wr_sel` = 3 loads the four fault enables from `wr_data[3:0]`, in the status bit order. A write with `wr_sel` = 4 loads the wakeup enable from `wr_data[0]`. `wr_sel` values 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mb_set | input | 32 | Per-mailbox set pulses from the message engine |
| st_set | input | 5 | Status set pulses (bus-off, error, tx warn, rx warn, wakeup) |
| fifo_en | input | 1 | Receive FIFO mode enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write target: 0 flag clear, 1 mask, 2 status clear, 3 fault enables, 4 wakeup enable |
| wr_data | input | 32 | Write data |
| flag_q | output | 32 | Visible mailbox flags |
| mask_q | output | 32 | Mailbox mask bits |
| stat_q | output | 5 | Status bits |
| irq_mb | output | 1 | Combined mailbox interrupt |
| irq_st | output | 5 | Per-source status interrupts |

## Verification
Two operations can hit the same flag or status bit in one cycle: a hardware set pulse and a software write-1-to-clear. The bench raises both on the same mailbox bit, and on the same status bit, within a single vector. It then requires the bit to read 1 after the edge. A second overlap is a FIFO-mode change in the same cycle as a set pulse on a low bit. For that case the bench checks that nothing shows in the flags or on the combined line, either then or after FIFO mode is turned off again.

// File: rtl/can_mb_irq_agg.sv
module can_mb_irq_agg #(
  parameter int NUM_MB    = 32,
  parameter int FIFO_BIT  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_MB-1:0] mb_set,
  input  logic [4:0]        st_set,
  input  logic              fifo_en,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [NUM_MB-1:0] wr_data,
  output logic [NUM_MB-1:0] flag_q,
  output logic [NUM_MB-1:0] mask_q,
  output logic [4:0]        stat_q,
  output logic              irq_mb,
  output logic [4:0]        irq_st
);

  localparam logic [2:0] SEL_FLAG = 3'd0;
  localparam logic [2:0] SEL_MASK = 3'd1;
  localparam logic [2:0] SEL_STAT = 3'd2;
  localparam logic [2:0] SEL_CTRL = 3'd3;
  localparam logic [2:0] SEL_WAKE = 3'd4;
  localparam logic [NUM_MB-1:0] LOW_BITS = NUM_MB'((64'd1 << FIFO_BIT) - 64'd1);

  logic [NUM_MB-1:0] flag_r, mask_r, keep, flag_clr, flag_nxt;
  logic [4:0]        stat_r, stat_clr;
  logic [3:0]        fault_en_r;
  logic              wake_en_r;

  assign keep     = fifo_en ? ~LOW_BITS : '1;
  assign flag_clr = (wr_en && wr_sel == SEL_FLAG) ? wr_data : '0;
  assign flag_nxt = ((flag_r & ~flag_clr) | mb_set) & keep;
  assign stat_clr = (wr_en && wr_sel == SEL_STAT) ? wr_data[4:0] : 5'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_r     <= '0;
      mask_r     <= '0;
      stat_r     <= '0;
      fault_en_r <= '0;
      wake_en_r  <= 1'b0;
    end else begin
      flag_r <= flag_nxt;
      stat_r <= (stat_r & ~stat_clr) | st_set;
      if (wr_en && wr_sel == SEL_MASK) mask_r     <= wr_data;
      if (wr_en && wr_sel == SEL_CTRL) fault_en_r <= wr_data[3:0];
      if (wr_en && wr_sel == SEL_WAKE) wake_en_r  <= wr_data[0];
    end
  end

  assign flag_q = flag_r & keep;
  assign mask_q = mask_r;
  assign stat_q = stat_r;
  assign irq_mb = |(flag_q & mask_r);
  assign irq_st = stat_r & {wake_en_r, fault_en_r};

  // R2 / R4: a set pulse on a live bit always lands
  p_set_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    |(mb_set & keep) |=> ((flag_r & $past(mb_set & keep)) == $past(mb_set & keep)));

  // R3: written ones clear when no set collides
  p_w1c_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_FLAG && mb_set == '0) |=> ((flag_r & $past(wr_data)) == '0));

  // R6: mask writes leave flags alone
  p_mask_keeps_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_MASK && mb_set == '0 && !fifo_en) |=> $stable(flag_r));

  // R7: low bits hold no state across a FIFO-mode cycle
  p_fifo_low_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_en |=> ((flag_r & LOW_BITS) == '0));

  // R8: status set pulses always land
  p_stat_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    |st_set |=> ((stat_r & $past(st_set)) == $past(st_set)));

  // R9: an interrupt needs a pending status bit
  p_irq_needs_stat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_st & ~stat_q) == 5'd0));

endmodule

// File: tb/can_mb_irq_agg_test.sv
module can_mb_irq_agg_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] mb_set = '0;
  logic [4:0]  st_set = '0;
  logic        fifo_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] flag_q, mask_q;
  logic [4:0]  stat_q, irq_st;
  logic        irq_mb;
  int          n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  can_mb_irq_agg uut (.clk(clk), .rst_n(rst_n), .mb_set(mb_set), .st_set(st_set),
    .fifo_en(fifo_en), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .flag_q(flag_q), .mask_q(mask_q), .stat_q(stat_q), .irq_mb(irq_mb), .irq_st(irq_st));

  typedef struct packed {
    logic [31:0] set; logic fifo; logic we; logic [2:0] sel; logic [31:0] data;
    logic [4:0] st; logic [31:0] ef; logic [31:0] em; logic [4:0] es; logic ei; logic [4:0] eis;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t TBL [NV] = '{
    '{32'h0000_0101, 1'b0, 1'b0, 3'd0, 32'h0,         5'h00, 32'h0000_0101, 32'h0,         5'h00, 1'b0, 5'h00}, // R2
    '{32'h0,         1'b0, 1'b1, 3'd1, 32'h0000_0100, 5'h00, 32'h0000_0101, 32'h0000_0100, 5'h00, 1'b1, 5'h00}, // R6 R5
    '{32'h0,         1'b0, 1'b1, 3'd0, 32'h0000_0001, 5'h00, 32'h0000_0100, 32'h0000_0100, 5'h00, 1'b1, 5'h00}, // R3
    '{32'h0,         1'b0, 1'b1, 3'd0, 32'h0,         5'h00, 32'h0000_0100, 32'h0000_0100, 5'h00, 1'b1, 5'h00}, // R3 zero
    '{32'h0000_0100, 1'b0, 1'b1, 3'd0, 32'h0000_0100, 5'h00, 32'h0000_0100, 32'h0000_0100, 5'h00, 1'b1, 5'h00}, // R4
    '{32'h0,         1'b0, 1'b1, 3'd0, 32'h0000_0100, 5'h00, 32'h0,         32'h0000_0100, 5'h00, 1'b0, 5'h00}, // R3 R5
    '{32'h8000_0000, 1'b0, 1'b0, 3'd0, 32'h0,         5'h00, 32'h8000_0000, 32'h0000_0100, 5'h00, 1'b0, 5'h00}, // R5 masked
    '{32'h0,         1'b0, 1'b1, 3'd1, 32'hFFFF_FFFF, 5'h00, 32'h8000_0000, 32'hFFFF_FFFF, 5'h00, 1'b1, 5'h00}, // R6
    '{32'h0000_003F, 1'b1, 1'b0, 3'd0, 32'h0,         5'h00, 32'h8000_0020, 32'hFFFF_FFFF, 5'h00, 1'b1, 5'h00}, // R7
    '{32'h0,         1'b1, 1'b1, 3'd0, 32'h8000_0000, 5'h00, 32'h0000_0020, 32'hFFFF_FFFF, 5'h00, 1'b1, 5'h00}, // R7 bit5
    '{32'h0,         1'b1, 1'b1, 3'd0, 32'h0000_0020, 5'h00, 32'h0,         32'hFFFF_FFFF, 5'h00, 1'b0, 5'h00}, // R7
    '{32'h0000_001F, 1'b1, 1'b0, 3'd0, 32'h0,         5'h00, 32'h0,         32'hFFFF_FFFF, 5'h00, 1'b0, 5'h00}, // R7 blocked
    '{32'h0000_0001, 1'b0, 1'b0, 3'd0, 32'h0,         5'h00, 32'h0000_0001, 32'hFFFF_FFFF, 5'h00, 1'b1, 5'h00}, // R2 low bit
    '{32'h0,         1'b1, 1'b0, 3'd0, 32'h0,         5'h00, 32'h0,         32'hFFFF_FFFF, 5'h00, 1'b0, 5'h00}, // R7 hidden
    '{32'h0,         1'b0, 1'b0, 3'd0, 32'h0,         5'h00, 32'h0,         32'hFFFF_FFFF, 5'h00, 1'b0, 5'h00}, // R7 discarded
    '{32'h0,         1'b0, 1'b0, 3'd0, 32'h0,         5'h1F, 32'h0,         32'hFFFF_FFFF, 5'h1F, 1'b0, 5'h00}, // R8 R9
    '{32'h0,         1'b0, 1'b1, 3'd3, 32'h0000_000F, 5'h00, 32'h0,         32'hFFFF_FFFF, 5'h1F, 1'b0, 5'h0F}, // R9
    '{32'h0,         1'b0, 1'b1, 3'd4, 32'h0000_0001, 5'h00, 32'h0,         32'hFFFF_FFFF, 5'h1F, 1'b0, 5'h1F}, // R9 wake
    '{32'h0,         1'b0, 1'b1, 3'd2, 32'h0000_0005, 5'h00, 32'h0,         32'hFFFF_FFFF, 5'h1A, 1'b0, 5'h1A}, // R8
    '{32'h0,         1'b0, 1'b1, 3'd2, 32'h0000_0002, 5'h02, 32'h0,         32'hFFFF_FFFF, 5'h1A, 1'b0, 5'h1A}, // R8 set wins
    '{32'h0,         1'b0, 1'b1, 3'd3, 32'h0,         5'h00, 32'h0,         32'hFFFF_FFFF, 5'h1A, 1'b0, 5'h10}, // R9
    '{32'h0,         1'b0, 1'b1, 3'd5, 32'hFFFF_FFFF, 5'h00, 32'h0,         32'hFFFF_FFFF, 5'h1A, 1'b0, 5'h10}  // R9 unmapped
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog got=timeout exp=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 flag", flag_q, 32'h0);
    chk("R1 mask", mask_q, 32'h0);
    chk("R1 stat", 32'(stat_q), 32'h0);
    chk("R1 irq", {26'h0, irq_st, irq_mb}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      mb_set = TBL[i].set; fifo_en = TBL[i].fifo; wr_en = TBL[i].we;
      wr_sel = TBL[i].sel; wr_data = TBL[i].data; st_set = TBL[i].st;
      @(posedge clk);
      @(negedge clk);
      mb_set = '0; st_set = '0; wr_en = 1'b0;
      chk($sformatf("R2/R3/R4/R7 flag v%0d", i), flag_q, TBL[i].ef);
      chk($sformatf("R6 mask v%0d", i), mask_q, TBL[i].em);
      chk($sformatf("R8 stat v%0d", i), 32'(stat_q), 32'(TBL[i].es));
      chk($sformatf("R5 irq_mb v%0d", i), 32'(irq_mb), 32'(TBL[i].ei));
      chk($sformatf("R9 irq_st v%0d", i), 32'(irq_st), 32'(TBL[i].eis));
    end

    // R2: flag holds over idle cycles
    fifo_en = 1'b0; mb_set = 32'h0000_4000;
    @(posedge clk); @(negedge clk); mb_set = '0;
    repeat (4) @(negedge clk);
    chk("R2 hold", flag_q, 32'h0000_4000);
    chk("R5 hold irq", 32'(irq_mb), 32'h1);

    // R1: reset mid-run clears everything
    rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    rst_n = 1'b1;
    chk("R1 rerst flag", flag_q, 32'h0);
    chk("R1 rerst mask", mask_q, 32'h0);
    chk("R1 rerst stat", 32'(stat_q), 32'h0);
    // R9: enables were reset too
    st_set = 5'h1F;
    @(posedge clk); @(negedge clk); st_set = '0;
    chk("R1 rerst irq_st", 32'(irq_st), 32'h0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule